// File: doc/BRIEF.md
# Keyboard matrix scanner with debounce

This block drives the row scan of a key matrix of up to 8 rows by 8 columns and watches eight active-low return lines. Each valid key depression becomes one 8-bit key code, published with a single-cycle push strobe toward a downstream key FIFO. The code also carries the levels of the SHIFT and CNTL inputs. The scan moves forward one slot per `tick_i` pulse, which comes from an external prescaler. Two scan styles are available. In binary style, `scan_o` counts 0 to 15 and an external decoder turns it into row selects. In one-of-four style, `scan_o` drives an active-low row select directly and only four rows exist.

Debounce is per key. A closure counts only if the key is still closed two whole scans after it was first seen. Two policies decide between keys. Two-key lockout withholds every new key while more than one key is debouncing. N-key rollover lets each key debounce on its own. With rollover, an optional error check reports simultaneous fresh closures. The downstream FIFO reports that it is full through `fifo_full_i`. A key accepted while the FIFO is full is not pushed, and an error pulse is raised instead.

Top module: `keyscan_ctrl`

## Requirements
- R1: Out of reset `scan_o` is 0000, `push_o` and `err_o` are low and `code_o` is 0x00.
- R2: With `decoded_i` low, `scan_o` is a binary count that steps by one on each `tick_i` and wraps from 15 to 0. Keys are sampled only in slots 0 to 7, and the row number is the low three bits of the count.
- R3: With `decoded_i` high, `scan_o` steps through 1110, 1101, 1011, 0111 and repeats. The row number is the position of the low bit, 0 to 3, and keys in rows 4 to 7 are never reported.
- R4: A return line that is low marks a closed key, and its bit index is the column. The code is bit 7 = `cntl_i`, bit 6 = `shift_i` (the levels present at the sampling tick), bits 5:3 = row and bits 2:0 = column.
- R5: A key is reported at the third consecutive scan in which it is sampled closed. A key that opens before that produces no code.
- R6: A held key is reported once only. After the key has been sampled open, a new press is reported again.
- R7: `push_o` and `err_o` pulse only in the cycle that follows a `tick_i` edge, and the row field of the code is the row sampled at that edge.
- R8: With `nkro_i` low, no key is reported while two or more not-yet-reported keys are held. The key that remains is reported two scans after it is first sampled alone. A key pressed while an already-reported key is held is reported normally.
- R9: With `nkro_i` high, keys debounce independently and are reported in scan order. When two keys of one row are ready together, the lower column is reported first and the other one scan later.
- R10: With `nkro_i` and `spec_err_i` both high, `err_o` pulses at the end of any scan in which two or more not-yet-reported keys were sampled closed. No such pulse occurs when either input is low.
- R11: A key accepted while `fifo_full_i` is high gives no push and exactly one `err_o` pulse, and it still counts as reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan advance pulse from the prescaler |
| decoded_i | input | 1 | 1 = one-of-four row select, 0 = binary count |
| nkro_i | input | 1 | 1 = N-key rollover, 0 = two-key lockout |
| spec_err_i | input | 1 | Enables the simultaneous-press error under rollover |
| fifo_full_i | input | 1 | Downstream key FIFO has no free entry |
| ret_ni | input | 8 | Return lines, low = key closed in the active row |
| shift_i | input | 1 | SHIFT level, copied into code bit 6 |
| cntl_i | input | 1 | CNTL level, copied into code bit 7 |
| scan_o | output | 4 | Row scan output |
| push_o | output | 1 | One-cycle key code push strobe |
| code_o | output | 8 | Key code that goes with `push_o` |
| err_o | output | 1 | One-cycle error flag set pulse |

## Verification
Push, code and error outputs are registered. Each one shows up in the cycle right after the `tick_i` edge that sampled the row, and `scan_o` changes on that same edge. A key is reported on its third sampled scan, so the bench first aligns to the start of a scan. It presses keys there and counts pushes at whole-scan boundaries, one tick interval later than the last possible sampling edge. This lets the check before the third scan expect nothing and the check after it expect the code. A running monitor records each pulse one cycle after the edge that produced it, and checks that a tick occurred at that edge and that the row field matches the row scanned there.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  // per-key debounce state
  typedef enum logic [1:0] {
    K_OPEN  = 2'd0,
    K_SEEN1 = 2'd1,
    K_SEEN2 = 2'd2,
    K_DONE  = 2'd3
  } key_st_e;
endpackage

// File: rtl/keyscan_scan_ctr.sv
module keyscan_scan_ctr #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned ROWS  = 8,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned DEC_W = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             decoded_i,
  output logic [CNT_W-1:0] scan_o,
  output logic [ROW_W-1:0] row_o,
  output logic             row_vld_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [DEC_W-1:0] dec_idx;
  logic [CNT_W-1:0] dec_lines;

  assign dec_idx = cnt_q[DEC_W-1:0];
  assign last_o  = decoded_i ? (dec_idx == DEC_W'(CNT_W - 1)) : (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_dec
    assign dec_lines[i] = (dec_idx != DEC_W'(i));
  end

  assign scan_o    = decoded_i ? dec_lines : cnt_q;
  assign row_o     = decoded_i ? ROW_W'(dec_idx) : cnt_q[ROW_W-1:0];
  // binary style: upper half of the count is display-only
  assign row_vld_o = decoded_i | ((cnt_q >> ROW_W) == '0);
endmodule

// File: rtl/keyscan_row_eval.sv
module keyscan_row_eval
  import keyscan_pkg::*;
#(
  parameter int unsigned COLS = 8,
  localparam int unsigned COL_W   = $clog2(COLS),
  localparam int unsigned FRESH_W = $clog2(COLS + 1)
) (
  input  logic [COLS-1:0][1:0]  st_i,
  input  logic [COLS-1:0]       closed_i,
  input  logic                  lock_i,
  output logic [COLS-1:0][1:0]  st_o,
  output logic                  hit_o,
  output logic [COL_W-1:0]      col_o,
  output logic [FRESH_W-1:0]    fresh_o
);
  logic [COLS-1:0] ready;

  for (genvar c = 0; c < COLS; c++) begin : g_rdy
    assign ready[c] = closed_i[c] && (st_i[c] == K_SEEN2) && !lock_i;
  end

  // lowest ready column wins this slot
  always_comb begin
    col_o = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (ready[c]) col_o = COL_W'(c);
    end
  end
  assign hit_o = |ready;

  always_comb begin
    fresh_o = '0;
    for (int c = 0; c < COLS; c++) begin
      if (closed_i[c] && st_i[c] != K_DONE) fresh_o = fresh_o + 1'b1;
    end
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      if (!closed_i[c])            st_o[c] = K_OPEN;
      else if (st_i[c] == K_DONE)  st_o[c] = K_DONE;
      else if (lock_i)             st_o[c] = K_SEEN1;
      else begin
        case (st_i[c])
          K_OPEN:  st_o[c] = K_SEEN1;
          K_SEEN1: st_o[c] = K_SEEN2;
          default: st_o[c] = (hit_o && col_o == COL_W'(c)) ? K_DONE : K_SEEN2;
        endcase
      end
    end
  end
endmodule

// File: rtl/keyscan_key_table.sv
module keyscan_key_table #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [COLS-1:0][1:0] wdata_i,
  output logic [COLS-1:0][1:0] rdata_o
);
  logic [COLS-1:0][1:0] st_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          st_q[r] <= '0;
      else if (we_i && row_i == ROW_W'(r))  st_q[r] <= wdata_i;
    end
  end

  assign rdata_o = st_q[row_i];
endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned COLS  = 8,
  parameter int unsigned CNT_W = 4,
  localparam int unsigned ROW_W   = $clog2(ROWS),
  localparam int unsigned COL_W   = $clog2(COLS),
  localparam int unsigned CODE_W  = 2 + ROW_W + COL_W,
  localparam int unsigned FRESH_W = $clog2(COLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              decoded_i,
  input  logic              nkro_i,
  input  logic              spec_err_i,
  input  logic              fifo_full_i,
  input  logic [COLS-1:0]   ret_ni,
  input  logic              shift_i,
  input  logic              cntl_i,
  output logic [CNT_W-1:0]  scan_o,
  output logic              push_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o
);
  logic [ROW_W-1:0]     row;
  logic                 row_vld, last, sample, lock;
  logic [COLS-1:0][1:0] st_cur, st_nxt;
  logic                 hit;
  logic [COL_W-1:0]     col;
  logic [FRESH_W-1:0]   fresh;
  logic                 crowd_q;
  logic [1:0]           seen_q, scan_sum;
  logic [2:0]           sum_raw;
  logic                 push_q, err_q;
  logic [CODE_W-1:0]    code_q;

  keyscan_scan_ctr #(.CNT_W(CNT_W), .ROWS(ROWS)) u_scan (
    .clk_i, .rst_ni, .tick_i, .decoded_i,
    .scan_o, .row_o(row), .row_vld_o(row_vld), .last_o(last)
  );

  assign sample = tick_i & row_vld;
  assign lock   = !nkro_i && crowd_q;

  keyscan_row_eval #(.COLS(COLS)) u_eval (
    .st_i(st_cur), .closed_i(~ret_ni), .lock_i(lock),
    .st_o(st_nxt), .hit_o(hit), .col_o(col), .fresh_o(fresh)
  );

  keyscan_key_table #(.ROWS(ROWS), .COLS(COLS)) u_table (
    .clk_i, .rst_ni, .we_i(sample), .row_i(row),
    .wdata_i(st_nxt), .rdata_o(st_cur)
  );

  // saturating (0,1,2+) count of unreported closed keys over the scan
  always_comb begin
    sum_raw = {1'b0, seen_q};
    if (sample) sum_raw = sum_raw + ((fresh > FRESH_W'(1)) ? 3'd2 : 3'(fresh));
    scan_sum = (sum_raw >= 3'd2) ? 2'd2 : sum_raw[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= '0;
      crowd_q <= 1'b0;
    end else if (tick_i) begin
      if (last) begin
        seen_q  <= '0;
        crowd_q <= (scan_sum == 2'd2);
      end else begin
        seen_q  <= scan_sum;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      push_q <= sample && hit && !fifo_full_i;
      err_q  <= (sample && hit && fifo_full_i) ||
                (tick_i && last && nkro_i && spec_err_i && scan_sum == 2'd2);
      if (sample && hit) code_q <= {cntl_i, shift_i, row, col};
    end
  end

  assign push_o = push_q;
  assign err_o  = err_q;
  assign code_o = code_q;
endmodule

// File: rtl/keyscan_ctrl_chk.sv
module keyscan_ctrl_chk #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned COLS  = 8,
  parameter int unsigned CNT_W = 4,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned CODE_W = 2 + ROW_W + COL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              decoded_i,
  input logic              fifo_full_i,
  input logic [COLS-1:0]   ret_ni,
  input logic              shift_i,
  input logic              cntl_i,
  input logic [CNT_W-1:0]  scan_o,
  input logic              push_o,
  input logic [CODE_W-1:0] code_o,
  input logic              err_o
);
  p_scan_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !decoded_i |=> decoded_i || scan_o == CNT_W'($past(scan_o) + 1'b1));

  p_scan_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !decoded_i |=> decoded_i || $stable(scan_o));

  p_dec_rotate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && decoded_i |=> !decoded_i ||
      scan_o == {$past(scan_o[CNT_W-2:0]), $past(scan_o[CNT_W-1])});

  p_dec_rows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && $past(decoded_i) |-> code_o[COL_W+ROW_W-1] == 1'b0);

  p_code_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && !$past(decoded_i) |-> code_o[COL_W +: ROW_W] == $past(scan_o[ROW_W-1:0]));

  p_code_mod_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> code_o[CODE_W-1] == $past(cntl_i) && code_o[CODE_W-2] == $past(shift_i));

  p_col_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ($past(ret_ni) & (COLS'(1) << code_o[COL_W-1:0])) == '0);

  p_push_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(tick_i));

  p_err_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(tick_i));

  p_no_push_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(fifo_full_i));
endmodule

bind keyscan_ctrl keyscan_ctrl_chk #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .decoded_i(decoded_i),
  .fifo_full_i(fifo_full_i), .ret_ni(ret_ni), .shift_i(shift_i), .cntl_i(cntl_i),
  .scan_o(scan_o), .push_o(push_o), .code_o(code_o), .err_o(err_o)
);

// File: tb/keyscan_ctrl_bench.sv
`timescale 1ns/1ps
module keyscan_ctrl_bench;
  localparam int G = 3;  // cycles per tick

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick = 1'b0;
  logic       decoded, nkro, spec_err, fifo_full, shift, cntl;
  logic [7:0] ret_n;
  logic [3:0] scan;
  logic       push, err;
  logic [7:0] code;

  logic [7:0] key_m [8];
  logic [7:0] log_code [256];
  int         ncode = 0, nerr = 0, timing_bad = 0;
  int         base_c, base_e;
  int         nchk = 0, nbad = 0;
  logic       tick_seen = 1'b0;
  logic [2:0] row_seen = '0;

  always #4 clk = ~clk;

  keyscan_ctrl u_keyscan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .decoded_i(decoded),
    .nkro_i(nkro), .spec_err_i(spec_err), .fifo_full_i(fifo_full),
    .ret_ni(ret_n), .shift_i(shift), .cntl_i(cntl),
    .scan_o(scan), .push_o(push), .code_o(code), .err_o(err)
  );

  // key matrix model
  always_comb begin
    ret_n = '1;
    if (!decoded) ret_n = ~key_m[scan[2:0]];
    else for (int i = 0; i < 4; i++) if (!scan[i]) ret_n = ~key_m[i];
  end

  function automatic logic [2:0] cur_row();
    if (!decoded) return scan[2:0];
    for (int i = 0; i < 4; i++) if (!scan[i]) return 3'(i);
    return 3'd0;
  endfunction

  initial begin
    forever begin
      repeat (G - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(posedge clk) begin
    tick_seen <= tick;
    row_seen  <= cur_row();
  end

  always @(negedge clk) begin
    if (push) begin
      log_code[ncode[7:0]] = code;
      ncode = ncode + 1;
      if (!tick_seen || code[5:3] != row_seen) timing_bad = timing_bad + 1;
    end
    if (err) begin
      nerr = nerr + 1;
      if (!tick_seen) timing_bad = timing_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * G) @(negedge clk);
    #1;
  endtask

  task automatic wait_scans(input int n);
    wait_ticks(n * (decoded ? 4 : 16));
  endtask

  task automatic sync_scan();
    logic [3:0] first;
    first = decoded ? 4'b1110 : 4'b0000;
    do @(negedge clk); while (!(tick_seen && scan == first));
    #1;
  endtask

  task automatic idle();
    for (int r = 0; r < 8; r++) key_m[r] = '0;
    shift = 1'b1; cntl = 1'b1;
    wait_scans(3);
    base_c = ncode; base_e = nerr;
  endtask

  task automatic t_reset();
    chk(scan == 4'd0, "R1 scan", scan, 0);
    chk(push == 1'b0 && err == 1'b0, "R1 strobes", {push, err}, 0);
    chk(code == 8'h00, "R1 code", code, 0);
  endtask

  task automatic t_scan();
    sync_scan();
    chk(scan == 4'd0, "R2 start", scan, 0);
    for (int k = 1; k <= 5; k++) begin
      wait_ticks(1);
      chk(scan == 4'(k), "R2 step", scan, k);
    end
    wait_ticks(10);
    chk(scan == 4'd15, "R2 top", scan, 15);
    wait_ticks(1);
    chk(scan == 4'd0, "R2 wrap", scan, 0);
    decoded = 1'b1;
    sync_scan();
    chk(scan == 4'b1110, "R3 slot0", scan, 4'b1110);
    wait_ticks(1); chk(scan == 4'b1101, "R3 slot1", scan, 4'b1101);
    wait_ticks(1); chk(scan == 4'b1011, "R3 slot2", scan, 4'b1011);
    wait_ticks(1); chk(scan == 4'b0111, "R3 slot3", scan, 4'b0111);
    wait_ticks(1); chk(scan == 4'b1110, "R3 wrap", scan, 4'b1110);
    decoded = 1'b0;
    idle();
  endtask

  task automatic t_single();
    sync_scan();
    key_m[2][4] = 1'b1;
    wait_scans(2);
    chk(ncode == base_c, "R5 not before third scan", ncode - base_c, 0);
    wait_scans(1);
    chk(ncode == base_c + 1, "R5 on third scan", ncode - base_c, 1);
    chk(log_code[base_c[7:0]] == 8'hD4, "R4 code", log_code[base_c[7:0]], 8'hD4);
    wait_scans(4);
    chk(ncode == base_c + 1, "R6 held once", ncode - base_c, 1);
    key_m[2][4] = 1'b0;
    wait_scans(2);
    shift = 1'b0;
    key_m[2][4] = 1'b1;
    wait_scans(4);
    chk(ncode == base_c + 2, "R6 re-press", ncode - base_c, 2);
    chk(log_code[8'(base_c + 1)] == 8'h94, "R4 shift low", log_code[8'(base_c + 1)], 8'h94);
    idle();
  endtask

  task automatic t_bounce();
    sync_scan();
    key_m[3][3] = 1'b1;
    wait_scans(2);
    key_m[3][3] = 1'b0;
    wait_scans(4);
    chk(ncode == base_c, "R5 short press", ncode - base_c, 0);
    idle();
  endtask

  task automatic t_lockout();
    nkro = 1'b0; spec_err = 1'b1;
    sync_scan();
    key_m[2][1] = 1'b1; key_m[4][5] = 1'b1;
    wait_scans(6);
    chk(ncode == base_c, "R8 both held", ncode - base_c, 0);
    chk(nerr == base_e, "R10 no error in lockout", nerr - base_e, 0);
    key_m[4][5] = 1'b0;
    wait_scans(4);
    chk(ncode == base_c + 1, "R8 survivor", ncode - base_c, 1);
    chk(log_code[base_c[7:0]] == 8'hD1, "R8 survivor code", log_code[base_c[7:0]], 8'hD1);
    key_m[7][7] = 1'b1;
    wait_scans(4);
    chk(ncode == base_c + 2, "R8 press over held key", ncode - base_c, 2);
    chk(log_code[8'(base_c + 1)] == 8'hFF, "R8 second code", log_code[8'(base_c + 1)], 8'hFF);
    spec_err = 1'b0;
    idle();
  endtask

  task automatic t_rollover();
    nkro = 1'b1; spec_err = 1'b0;
    sync_scan();
    key_m[1][3] = 1'b1; key_m[5][0] = 1'b1;
    wait_scans(4);
    chk(ncode == base_c + 2, "R9 both reported", ncode - base_c, 2);
    chk(log_code[base_c[7:0]] == 8'hCB, "R9 first row1", log_code[base_c[7:0]], 8'hCB);
    chk(log_code[8'(base_c + 1)] == 8'hE8, "R9 then row5", log_code[8'(base_c + 1)], 8'hE8);
    chk(nerr == base_e, "R10 off gives no error", nerr - base_e, 0);
    idle();
    sync_scan();
    key_m[3][2] = 1'b1; key_m[3][6] = 1'b1;
    wait_scans(3);
    chk(ncode == base_c + 1, "R9 one per slot", ncode - base_c, 1);
    wait_scans(1);
    chk(ncode == base_c + 2, "R9 same row both", ncode - base_c, 2);
    chk(log_code[base_c[7:0]] == 8'hDA, "R9 low column first", log_code[base_c[7:0]], 8'hDA);
    chk(log_code[8'(base_c + 1)] == 8'hDE, "R9 high column next", log_code[8'(base_c + 1)], 8'hDE);
    idle();
  endtask

  task automatic t_special();
    nkro = 1'b1; spec_err = 1'b1;
    sync_scan();
    key_m[0][1] = 1'b1; key_m[6][2] = 1'b1;
    wait_scans(4);
    chk(nerr > base_e, "R10 simultaneous error", nerr - base_e, 1);
    chk(ncode == base_c + 2, "R10 codes still pushed", ncode - base_c, 2);
    spec_err = 1'b0;
    idle();
  endtask

  task automatic t_full();
    nkro = 1'b0;
    fifo_full = 1'b1;
    sync_scan();
    key_m[0][0] = 1'b1;
    wait_scans(4);
    chk(ncode == base_c, "R11 no push when full", ncode - base_c, 0);
    chk(nerr == base_e + 1, "R11 one overrun pulse", nerr - base_e, 1);
    fifo_full = 1'b0;
    wait_scans(3);
    chk(ncode == base_c, "R11 counted as reported", ncode - base_c, 0);
    idle();
  endtask

  task automatic t_decoded();
    decoded = 1'b1;
    sync_scan();
    key_m[1][7] = 1'b1; key_m[6][0] = 1'b1;
    wait_scans(4);
    chk(ncode == base_c + 1, "R3 only rows 0-3", ncode - base_c, 1);
    chk(log_code[base_c[7:0]] == 8'hCF, "R3 decoded code", log_code[base_c[7:0]], 8'hCF);
    idle();
    decoded = 1'b0;
    wait_scans(1);
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) key_m[r] = '0;
    decoded = 1'b0; nkro = 1'b0; spec_err = 1'b0; fifo_full = 1'b0;
    shift = 1'b1; cntl = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    base_c = ncode; base_e = nerr;
    t_scan();
    t_single();
    t_bounce();
    t_lockout();
    t_rollover();
    t_special();
    t_full();
    t_decoded();
    chk(timing_bad == 0, "R7 strobe timing and row", timing_bad, 0);
    chk(ncode > 0, "R7 pushes observed", ncode, 1);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule